// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a serial memory slave's protocol engine and turns one write transaction into one programming event. The protocol side signals that a write has started, with the target address, then hands over each received data byte, and finally reports the stop condition. The block gathers the bytes into a one-page staging buffer. Only the six low address bits advance from byte to byte, so a run that crosses the end of a page wraps back to the start of that same page, and later bytes replace earlier ones.

Nothing touches the array until the stop arrives. If at least one byte was collected and the write-protect input is low at that moment, the block drains every collected byte to the array write port and holds `busy` for the programming time. The programming time is a clock-cycle count supplied on an input. While `busy` is high, every transaction input is ignored. After each stop, the block exposes the current-address pointer for later current-address reads.

Top module: `page_commit_seq`

## Requirements
- R1: After synchronous reset, `busy` and `mem_we` are 0 and `cur_ptr` is 0.
- R2: A transaction with one data byte writes that byte to the start address. The write happens only after the stop, never before it.
- R3: Successive bytes go to successive offsets within the page, and the upper address bits stay those of the start address. After offset 63 the next byte goes to offset 0 of the same page.
- R4: When more than 64 bytes are sent, each offset keeps the last byte that landed on it. Each offset is written to the array at most once per commit.
- R5: Only offsets that received a byte in the transaction are written. Every other location of the page receives no write.
- R6: A stop after at least one byte, with `wp_pin` low, raises `busy` in the cycle after the stop. `busy` stays high for exactly max(`wr_cycles`, 66) cycles, and all array writes of the commit fall inside that window.
- R7: If `wp_pin` is high when the stop is accepted, no array write occurs and `busy` stays low.
- R8: A stop with no data byte (a pointer-setting write) causes no array write and no `busy`. `cur_ptr` becomes the start address.
- R9: After any accepted stop, `cur_ptr` holds {page of the start address, offset one past the last received byte, wrapped within the page}.
- R10: While `busy` is high, start, byte and stop inputs have no effect: no write is buffered, `cur_ptr` does not change and no second commit follows.
- R11: Byte and stop strobes arriving outside a started transaction are ignored: no write, no `busy`, no change to `cur_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_begin | input | 1 | Write transaction starts; `wr_addr` is valid |
| wr_addr | input | 15 | Start address of the write |
| byte_valid | input | 1 | One data byte received |
| byte_data | input | 8 | Received data byte |
| stop_seen | input | 1 | Stop condition ends the transaction |
| wp_pin | input | 1 | Write protect, high blocks the commit |
| wr_cycles | input | 20 | Programming time in clock cycles |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming in progress |
| cur_ptr | output | 15 | Current-address pointer |

## Verification
The bench targets page wrap starting near offset 63. A design that carried into the upper address bits would scatter bytes into the next page. It also sends a 70-byte burst, where a design without overwrite would drop or double-write the first six offsets. Bytes are also sent with write protect high, and a stop is sent with no bytes. Each should leave the array and `busy` untouched, where a careless design would program anyway or hold the bus. Finally, traffic is injected while `busy` is high and without a preceding start, which exposes a design that buffers it and issues a second commit or moves the pointer.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HOLD  = 2'd2
  } pws_state_e;
endpackage

// File: rtl/pws_addr_track.sv
module pws_addr_track #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy,
  input  logic                    wr_begin,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic                    byte_valid,
  input  logic                    stop_seen,
  output logic                    begin_acc,
  output logic                    byte_acc,
  output logic                    stop_acc,
  output logic [ADDR_W-OFF_W-1:0] page_base,
  output logic [OFF_W-1:0]        byte_off,
  output logic [ADDR_W-1:0]       cur_ptr
);
  localparam int PG_W = ADDR_W - OFF_W;

  logic              in_sess_q;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] ptr_q;

  assign stop_acc  = stop_seen & in_sess_q & ~busy;
  assign begin_acc = wr_begin & ~busy & ~stop_acc;
  assign byte_acc  = byte_valid & in_sess_q & ~busy & ~stop_seen & ~wr_begin;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sess_q <= 1'b0;
      page_q    <= '0;
      off_q     <= '0;
      ptr_q     <= '0;
    end else if (stop_acc) begin
      in_sess_q <= 1'b0;
      ptr_q     <= {page_q, off_q};
    end else if (begin_acc) begin
      in_sess_q <= 1'b1;
      page_q    <= wr_addr[ADDR_W-1:OFF_W];
      off_q     <= wr_addr[OFF_W-1:0];
    end else if (byte_acc) begin
      off_q     <= off_q + 1'b1;
    end
  end

  assign page_base = page_q;
  assign byte_off  = off_q;
  assign cur_ptr   = ptr_q;

  // R3: a received byte never moves the page base
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    byte_acc |=> (page_q == $past(page_q)));

  // R10: pointer frozen across a busy period
  p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ptr_q));
endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic [OFF_W-1:0] rd_off_q,
  output logic             has_data
);
  logic [7:0]            ram [0:PAGE_BYTES-1];
  logic [PAGE_BYTES-1:0] mask_q;

  // data store: no reset, one write port and one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_off] <= wr_data;
    rd_data <= ram[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask_q <= '0;
    end else begin
      if (wr_en) mask_q[wr_off] <= 1'b1;
      if (rd_en) mask_q[rd_off] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_off_q <= '0;
    end else begin
      rd_valid <= rd_en & mask_q[rd_off];
      rd_off_q <= rd_off;
    end
  end

  assign has_data = |mask_q;

  // R7: a clear leaves nothing pending
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> !has_data);
endmodule

// File: rtl/pws_commit_ctl.sv
module pws_commit_ctl
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int OFF_W      = 6,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [CNT_W-1:0]        wr_cycles,
  input  logic [ADDR_W-OFF_W-1:0] page_base,
  input  logic                    rd_valid,
  input  logic [7:0]              rd_data,
  input  logic [OFF_W-1:0]        rd_off_q,
  output logic                    rd_en,
  output logic [OFF_W-1:0]        rd_off,
  output logic                    busy,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [7:0]              mem_wdata
);
  localparam int PG_W = ADDR_W - OFF_W;
  localparam logic [CNT_W-1:0] DRAIN_CYC = CNT_W'(PAGE_BYTES + 2);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(PAGE_BYTES - 1);

  pws_state_e       state_q;
  logic [OFF_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;
  logic [PG_W-1:0]  cpage_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      limit_q <= DRAIN_CYC;
      cpage_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_DRAIN;
            idx_q   <= '0;
            cnt_q   <= CNT_W'(1);
            limit_q <= (wr_cycles < DRAIN_CYC) ? DRAIN_CYC : wr_cycles;
            cpage_q <= page_base;
            busy_q  <= 1'b1;
          end
        end
        ST_DRAIN: begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (idx_q == LAST_OFF) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (cnt_q == limit_q) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en  = (state_q == ST_DRAIN);
  assign rd_off = idx_q;
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= rd_valid;
      mem_addr  <= {cpage_q, rd_off_q};
      mem_wdata <= rd_data;
    end
  end

  // R6: array writes only happen inside the busy window
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_q);

  // R6: busy time never exceeds the latched limit
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= limit_q));

  // R6: an accepted commit raises busy on the next cycle
  p_go_busy_r6: assert property (@(posedge clk) disable iff (rst)
    go |=> busy_q);
endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop_seen,
  input  logic              wp_pin,
  input  logic [CNT_W-1:0]  wr_cycles,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_ptr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic             begin_acc, byte_acc, stop_acc;
  logic [PG_W-1:0]  page_base;
  logic [OFF_W-1:0] byte_off;
  logic             has_data;
  logic             rd_en, rd_valid;
  logic [OFF_W-1:0] rd_off, rd_off_q;
  logic [7:0]       rd_data;
  logic             go, discard;

  pws_addr_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_track (
    .clk(clk), .rst(rst), .busy(busy),
    .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_valid(byte_valid), .stop_seen(stop_seen),
    .begin_acc(begin_acc), .byte_acc(byte_acc), .stop_acc(stop_acc),
    .page_base(page_base), .byte_off(byte_off), .cur_ptr(cur_ptr)
  );

  assign go      = stop_acc & has_data & ~wp_pin;
  assign discard = stop_acc & wp_pin;

  pws_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .clr(begin_acc | discard),
    .wr_en(byte_acc), .wr_off(byte_off), .wr_data(byte_data),
    .rd_en(rd_en), .rd_off(rd_off),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_off_q(rd_off_q),
    .has_data(has_data)
  );

  pws_commit_ctl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .go(go), .wr_cycles(wr_cycles),
    .page_base(page_base),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_off_q(rd_off_q),
    .rd_en(rd_en), .rd_off(rd_off), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R7: protected stop never starts programming
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (stop_acc && wp_pin) |=> !busy);

  // R8: a stop with no collected byte leaves the block idle
  p_empty_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_acc && !has_data) |=> !busy);

  // R3: committed addresses stay in the page that was opened
  p_write_in_page_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == page_base));
endmodule

// File: tb/page_commit_seq_bench.sv
module page_commit_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_begin = 1'b0;
  logic [14:0] wr_addr = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        stop_seen = 1'b0;
  logic        wp_pin = 1'b0;
  logic [19:0] wr_cycles = 20'd100;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy;
  logic [14:0] cur_ptr;

  int nchk = 0;
  int nfail = 0;
  int wcount = 0;
  logic [7:0] model [int];
  bit done = 1'b0;

  always #4 clk = ~clk;

  page_commit_seq u_page_commit_seq (
    .clk(clk), .rst(rst), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_seen(stop_seen),
    .wp_pin(wp_pin), .wr_cycles(wr_cycles), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .cur_ptr(cur_ptr)
  );

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      model[int'(mem_addr)] = mem_wdata;
      wcount++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int rd_model(input int a);
    if (model.exists(a)) return int'(model[a]);
    return -1;
  endfunction

  task automatic send_begin(input logic [14:0] a);
    @(negedge clk); wr_begin = 1'b1; wr_addr = a;
    @(negedge clk); wr_begin = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic send_stop(output int len);
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    len = 0;
    while (busy && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic idle_watch(input int n, output int busy_seen);
    busy_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) busy_seen++;
    end
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);
    chk(cur_ptr == 15'd0, "R1", "cur_ptr after reset", int'(cur_ptr), 0);
  endtask

  task automatic t_byte_write();
    int len;
    int w0;
    w0 = wcount;
    wr_cycles = 20'd100;
    send_begin(15'h1234);
    send_byte(8'hA5);
    repeat (5) @(negedge clk);
    chk(wcount == w0, "R2", "writes before stop", wcount - w0, 0);
    send_stop(len);
    chk(len == 100, "R6", "busy length wr_cycles=100", len, 100);
    chk(rd_model(32'h1234) == 32'hA5, "R2", "byte at start address", rd_model(32'h1234), 32'hA5);
    chk(wcount - w0 == 1, "R5", "single write for one byte", wcount - w0, 1);
    chk(cur_ptr == 15'h1235, "R9", "pointer after byte write", int'(cur_ptr), 32'h1235);
  endtask

  task automatic t_page_wrap();
    int len;
    int w0;
    int bad;
    w0 = wcount;
    bad = 0;
    wr_cycles = 20'd10;
    send_begin(15'h043C);
    for (int i = 0; i < 8; i++) send_byte(8'h40 + 8'(i));
    send_stop(len);
    chk(len == 66, "R6", "busy length floor", len, 66);
    for (int i = 0; i < 8; i++) begin
      int a;
      a = 32'h0400 + ((60 + i) % 64);
      if (rd_model(a) != 32'h40 + i) bad++;
    end
    chk(bad == 0, "R3", "wrapped bytes in same page", bad, 0);
    chk(rd_model(32'h0440) == -1, "R3", "no carry into next page", rd_model(32'h0440), -1);
    chk(wcount - w0 == 8, "R5", "only received offsets written", wcount - w0, 8);
    chk(cur_ptr == 15'h0404, "R9", "pointer after wrap", int'(cur_ptr), 32'h0404);
  endtask

  task automatic t_overflow();
    int len;
    int w0;
    int bad;
    w0 = wcount;
    bad = 0;
    wr_cycles = 20'd80;
    send_begin(15'h0800);
    for (int i = 0; i < 70; i++) send_byte(8'(i));
    send_stop(len);
    for (int o = 0; o < 64; o++) begin
      int e;
      e = (o < 6) ? 64 + o : o;
      if (rd_model(32'h0800 + o) != e) bad++;
    end
    chk(bad == 0, "R4", "last byte per offset kept", bad, 0);
    chk(wcount - w0 == 64, "R4", "each offset written once", wcount - w0, 64);
    chk(len == 80, "R6", "busy length wr_cycles=80", len, 80);
    chk(cur_ptr == 15'h0806, "R9", "pointer after overflow", int'(cur_ptr), 32'h0806);
  endtask

  task automatic t_protect();
    int len;
    int w0;
    int extra;
    w0 = wcount;
    send_begin(15'h1234);
    send_byte(8'h5A);
    wp_pin = 1'b1;
    send_stop(len);
    idle_watch(80, extra);
    wp_pin = 1'b0;
    chk(len + extra == 0, "R7", "busy with protect", len + extra, 0);
    chk(wcount == w0, "R7", "writes with protect", wcount - w0, 0);
    chk(rd_model(32'h1234) == 32'hA5, "R7", "old contents kept", rd_model(32'h1234), 32'hA5);
  endtask

  task automatic t_dummy();
    int len;
    int w0;
    int extra;
    w0 = wcount;
    send_begin(15'h2222);
    send_stop(len);
    idle_watch(80, extra);
    chk(len + extra == 0, "R8", "busy on empty stop", len + extra, 0);
    chk(wcount == w0, "R8", "writes on empty stop", wcount - w0, 0);
    chk(cur_ptr == 15'h2222, "R8", "pointer set by empty write", int'(cur_ptr), 32'h2222);
  endtask

  task automatic t_busy_ignore();
    int w0;
    int extra;
    int len;
    w0 = wcount;
    wr_cycles = 20'd120;
    send_begin(15'h3000);
    send_byte(8'h11);
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    send_begin(15'h3100);
    send_byte(8'h22);
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    len = 0;
    while (busy && len < 5000) begin
      len++;
      @(negedge clk);
    end
    idle_watch(100, extra);
    chk(extra == 0, "R10", "no second commit", extra, 0);
    chk(wcount - w0 == 1, "R10", "only first byte committed", wcount - w0, 1);
    chk(rd_model(32'h3100) == -1, "R10", "busy-time byte dropped", rd_model(32'h3100), -1);
    chk(cur_ptr == 15'h3001, "R10", "pointer unchanged by busy traffic", int'(cur_ptr), 32'h3001);
  endtask

  task automatic t_orphan();
    int w0;
    int len;
    int extra;
    w0 = wcount;
    send_byte(8'h77);
    send_stop(len);
    idle_watch(80, extra);
    chk(len + extra == 0, "R11", "busy from orphan stop", len + extra, 0);
    chk(wcount == w0, "R11", "writes from orphan byte", wcount - w0, 0);
    chk(cur_ptr == 15'h3001, "R11", "pointer after orphan", int'(cur_ptr), 32'h3001);
  endtask

  initial begin
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overflow();
    t_protect();
    t_dummy();
    t_busy_ignore();
    t_orphan();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule